// File: doc/BRIEF.md
# Load Data Alignment and Extension

This block turns a raw 32-bit word read from data memory into the value a load writes back to a register. For byte and halfword loads it picks the addressed lane and extends it with sign or zero bits. Word loads pass through unchanged. The paired load-left and load-right operations assemble an unaligned word in two steps by merging part of the memory word into the previous contents of the target register. Halfword and word loads at a misaligned address raise an error flag. When that flag is raised, the old register value is returned unchanged.

The datapath is purely combinational. The only state is the byte-order mode, which is captured from a strap input on the first rising clock after reset release and held until the next reset. The caller supplies the load kind, the two low address bits, the memory word and the old register value. It uses the result in the same cycle.

Top module: `ldfmt_top`

## Requirements
- R1: The byte-order mode is big-endian while reset is asserted and until the first rising clock after reset release. On that edge the mode is taken from `endian_strap_i` (1 = big-endian, 0 = little-endian). Later changes of the strap have no effect until the next reset.
- R2: In big-endian mode, the byte at address offset k sits in bits [31-8k -: 8] of the memory word. In little-endian mode it sits in bits [8k+7 : 8k].
- R3: Kind code 0 (signed byte) returns the addressed byte with bit 7 copied into bits 31..8. For example, 0xFE gives 0xFFFFFFFE.
- R4: Kind code 1 (unsigned byte) returns the addressed byte with bits 31..8 cleared. For example, 0xFE gives 0x000000FE.
- R5: Kind codes 2 (signed) and 3 (unsigned) return the halfword at offset a, sign- or zero-extended. In big-endian mode the byte at offset a is the high byte. In little-endian mode it is the low byte.
- R6: Kind code 4 (word) at offset 0 returns the memory word unchanged.
- R7: A halfword load with address bit 0 set, or a word load with a nonzero offset, sets `addr_err_o`. In that case `result_o` equals `reg_old_i`.
- R8: Kind code 5 (load-left) in big-endian mode at offset k puts memory bytes k..3 in the top 4-k register bytes, keeping byte order. The low k bytes come from `reg_old_i`.
- R9: Kind code 6 (load-right) in big-endian mode at offset k puts memory bytes 0..k in the low k+1 register bytes. The upper 3-k bytes come from `reg_old_i`.
- R10: In little-endian mode, load-left and load-right at offset k produce the big-endian result for offset 3-k.
- R11: Byte loads, load-left and load-right never set `addr_err_o`, at any offset.
- R12: Kind code 7 is unused. It returns `reg_old_i` and never sets `addr_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for capturing the byte-order mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| endian_strap_i | input | 1 | Byte-order strap, sampled once after reset (1 = big-endian) |
| ld_kind_i | input | 3 | Load kind code (0..6 as in the requirements, 7 unused) |
| addr_lo_i | input | 2 | Low address bits, giving the byte offset |
| mem_word_i | input | 32 | Word read from data memory |
| reg_old_i | input | 32 | Current value of the target register |
| result_o | output | 32 | Value to write back |
| addr_err_o | output | 1 | Misaligned halfword or word load |

## Verification
The bench sweeps every offset in both byte orders. A design that steers lanes by the wrong endianness, or fails to mirror the offset for the merge operations, returns bytes in the wrong order or merges at the wrong boundary. It also checks the extension bit for signed and unsigned loads using top-bit-set data such as 0xFE, which catches swapped sign and zero extension. Separate checks cover the following cases:
- A misaligned halfword must raise the flag and keep the old register value.
- Load-left and load-right at offsets 0 and 3 must keep exactly the right number of old bytes, which catches an off-by-one merge mask.
- The strap is toggled after capture; a mode register without the one-shot enable would follow the toggle.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  typedef enum logic [2:0] {
    LK_BYTE_S  = 3'd0,
    LK_BYTE_U  = 3'd1,
    LK_HALF_S  = 3'd2,
    LK_HALF_U  = 3'd3,
    LK_WORD    = 3'd4,
    LK_LEFT    = 3'd5,
    LK_RIGHT   = 3'd6,
    LK_UNUSED  = 3'd7
  } ld_kind_e;
endpackage

// File: rtl/ldfmt_endian_cfg.sv
module ldfmt_endian_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  output logic big_endian_o,
  output logic armed_o
);
  logic be_q, be_d;
  logic armed_q, armed_d;
  logic cap_en;

  assign cap_en = armed_q;

  always_comb begin
    be_d    = be_q;
    armed_d = armed_q;
    if (cap_en) begin
      be_d    = strap_i;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q    <= 1'b1;
      armed_q <= 1'b1;
    end else if (cap_en) begin
      be_q    <= be_d;
      armed_q <= armed_d;
    end
  end

  assign big_endian_o = be_q;
  assign armed_o      = armed_q;
endmodule

// File: rtl/ldfmt_lane_sel.sv
module ldfmt_lane_sel #(
  parameter int NB  = 4,
  parameter int AW  = $clog2(NB)
) (
  input  logic          big_endian_i,
  input  logic [AW-1:0] offset_i,
  output logic [AW-1:0] lane_o,
  output logic [AW-1:0] merge_off_o
);
  localparam logic [AW-1:0] LAST = AW'(NB - 1);

  always_comb begin
    if (big_endian_i) begin
      lane_o      = LAST - offset_i;
      merge_off_o = offset_i;
    end else begin
      lane_o      = offset_i;
      merge_off_o = LAST - offset_i;
    end
  end
endmodule

// File: rtl/ldfmt_extend.sv
module ldfmt_extend
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W / 8,
  parameter int AW     = $clog2(NB)
) (
  input  ld_kind_e          kind_i,
  input  logic [AW-1:0]     offset_i,
  input  logic [AW-1:0]     lane_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] value_o,
  output logic              misalign_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int HW     = 16;

  logic [7:0]    byte_v;
  logic [HW-1:0] half_v;
  int            hidx;

  always_comb begin
    hidx   = int'(lane_i) / 2;
    byte_v = mem_i[int'(lane_i)*8 +: 8];
    half_v = mem_i[hidx*HW +: HW];
    value_o    = mem_i;
    misalign_o = 1'b0;
    unique case (kind_i)
      LK_BYTE_S: value_o = {{(DATA_W-8){byte_v[7]}}, byte_v};
      LK_BYTE_U: value_o = {{(DATA_W-8){1'b0}}, byte_v};
      LK_HALF_S: begin
        value_o    = {{(DATA_W-HW){half_v[HW-1]}}, half_v};
        misalign_o = offset_i[0];
      end
      LK_HALF_U: begin
        value_o    = {{(DATA_W-HW){1'b0}}, half_v};
        misalign_o = offset_i[0];
      end
      LK_WORD: begin
        value_o    = mem_i;
        misalign_o = (offset_i != '0);
      end
      default: begin
        value_o    = mem_i;
        misalign_o = 1'b0;
      end
    endcase
  end

  logic unused_w;
  assign unused_w = (HALF_W == 0);
endmodule

// File: rtl/ldfmt_merge.sv
module ldfmt_merge #(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W / 8,
  parameter int AW     = $clog2(NB)
) (
  input  logic [AW-1:0]     merge_off_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] old_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o
);
  int e;
  assign e = int'(merge_off_i);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_comb begin
      if (i >= e) left_o[i*8 +: 8] = mem_i[(i-e)*8 +: 8];
      else        left_o[i*8 +: 8] = old_i[i*8 +: 8];
      if (i <= e) right_o[i*8 +: 8] = mem_i[(i+NB-1-e)*8 +: 8];
      else        right_o[i*8 +: 8] = old_i[i*8 +: 8];
    end
  end
endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top
  import ldfmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W / 8,
  parameter int AW     = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              endian_strap_i,
  input  logic [2:0]        ld_kind_i,
  input  logic [AW-1:0]     addr_lo_i,
  input  logic [DATA_W-1:0] mem_word_i,
  input  logic [DATA_W-1:0] reg_old_i,
  output logic [DATA_W-1:0] result_o,
  output logic              addr_err_o
);
  ld_kind_e          kind;
  logic              big_endian;
  logic              cfg_armed;
  logic [AW-1:0]     lane;
  logic [AW-1:0]     merge_off;
  logic [DATA_W-1:0] ext_val;
  logic              ext_err;
  logic [DATA_W-1:0] left_val;
  logic [DATA_W-1:0] right_val;

  assign kind = ld_kind_e'(ld_kind_i);

  ldfmt_endian_cfg cfg_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_i      (endian_strap_i),
    .big_endian_o (big_endian),
    .armed_o      (cfg_armed)
  );

  ldfmt_lane_sel #(.NB(NB), .AW(AW)) lane_i (
    .big_endian_i (big_endian),
    .offset_i     (addr_lo_i),
    .lane_o       (lane),
    .merge_off_o  (merge_off)
  );

  ldfmt_extend #(.DATA_W(DATA_W), .NB(NB), .AW(AW)) ext_i (
    .kind_i     (kind),
    .offset_i   (addr_lo_i),
    .lane_i     (lane),
    .mem_i      (mem_word_i),
    .value_o    (ext_val),
    .misalign_o (ext_err)
  );

  ldfmt_merge #(.DATA_W(DATA_W), .NB(NB), .AW(AW)) mrg_i (
    .merge_off_i (merge_off),
    .mem_i       (mem_word_i),
    .old_i       (reg_old_i),
    .left_o      (left_val),
    .right_o     (right_val)
  );

  always_comb begin
    addr_err_o = 1'b0;
    unique case (kind)
      LK_LEFT:   result_o = left_val;
      LK_RIGHT:  result_o = right_val;
      LK_UNUSED: result_o = reg_old_i;
      default: begin
        addr_err_o = ext_err;
        result_o   = ext_err ? reg_old_i : ext_val;
      end
    endcase
  end
endmodule

// File: rtl/ldfmt_checker.sv
module ldfmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        big_endian,
  input logic        cfg_armed,
  input logic [2:0]  ld_kind_i,
  input logic [1:0]  addr_lo_i,
  input logic [31:0] mem_word_i,
  input logic [31:0] reg_old_i,
  input logic [31:0] result_o,
  input logic        addr_err_o
);
  // R1: once captured, the mode does not move
  assert_mode_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_armed |=> $stable(big_endian));

  // R1: capture happens on the first edge only
  assert_capture_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_armed |=> !cfg_armed);

  // R3
  assert_sign_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_kind_i == 3'd0) |-> (result_o[31:8] == {24{result_o[7]}}));

  // R4
  assert_zero_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_kind_i == 3'd1) |-> (result_o[31:8] == 24'd0));

  // R5
  assert_zero_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_kind_i == 3'd3 && !addr_lo_i[0]) |-> (result_o[31:16] == 16'd0));

  // R6
  assert_word_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_kind_i == 3'd4 && addr_lo_i == 2'd0) |-> (result_o == mem_word_i));

  // R7
  assert_misalign_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_kind_i inside {3'd2, 3'd3}) && addr_lo_i[0]) |-> addr_err_o);

  // R7
  assert_err_keeps_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_o |-> (result_o == reg_old_i));

  // R11
  assert_no_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_kind_i inside {3'd0, 3'd1, 3'd5, 3'd6}) |-> !addr_err_o);

  // R12
  assert_unused_kind_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_kind_i == 3'd7) |-> (!addr_err_o && result_o == reg_old_i));
endmodule

bind ldfmt_top ldfmt_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .big_endian (big_endian),
  .cfg_armed  (cfg_armed),
  .ld_kind_i  (ld_kind_i),
  .addr_lo_i  (addr_lo_i),
  .mem_word_i (mem_word_i),
  .reg_old_i  (reg_old_i),
  .result_o   (result_o),
  .addr_err_o (addr_err_o)
);

// File: tb/ldfmt_top_tb_top.sv
module ldfmt_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        strap;
  logic [2:0]  kind;
  logic [1:0]  addr;
  logic [31:0] mem;
  logic [31:0] old;
  logic [31:0] res;
  logic        err;
  int          total;
  int          bad;

  ldfmt_top dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .endian_strap_i (strap),
    .ld_kind_i      (kind),
    .addr_lo_i      (addr),
    .mem_word_i     (mem),
    .reg_old_i      (old),
    .result_o       (res),
    .addr_err_o     (err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // address-ordered byte k of the memory word
  function automatic logic [7:0] mbyte(input logic be, input logic [31:0] w, input int k);
    if (be) return w[31-8*k -: 8];
    return w[8*k +: 8];
  endfunction

  function automatic logic [32:0] model(input logic be, input logic [2:0] kd,
                                        input logic [1:0] a, input logic [31:0] w,
                                        input logic [31:0] o);
    logic [7:0]  b, b1;
    logic [15:0] h;
    logic [31:0] r;
    int          k, kk;
    k = int'(a);
    b = mbyte(be, w, k);
    r = o;
    case (kd)
      3'd0: return {1'b0, {24{b[7]}}, b};
      3'd1: return {1'b0, 24'd0, b};
      3'd2, 3'd3: begin
        if (a[0]) return {1'b1, o};
        b1 = mbyte(be, w, k + 1);
        h  = be ? {b, b1} : {b1, b};
        return (kd == 3'd2) ? {1'b0, {16{h[15]}}, h} : {1'b0, 16'd0, h};
      end
      3'd4: return (a != 2'd0) ? {1'b1, o} : {1'b0, w};
      3'd5: begin
        kk = be ? k : 3 - k;
        for (int j = 0; j + kk <= 3; j++) r[31-8*j -: 8] = mbyte(1'b1, w, kk + j);
        return {1'b0, r};
      end
      3'd6: begin
        kk = be ? k : 3 - k;
        for (int j = 0; j <= kk; j++) r[8*j +: 8] = mbyte(1'b1, w, kk - j);
        return {1'b0, r};
      end
      default: return {1'b0, o};
    endcase
  endfunction

  task automatic check(input string req, input logic be, input logic [2:0] kd,
                       input logic [1:0] a, input logic [31:0] w, input logic [31:0] o);
    logic [32:0] exp;
    @(negedge clk);
    kind = kd; addr = a; mem = w; old = o;
    #1;
    exp = model(be, kd, a, w, o);
    total++;
    if ({err, res} !== exp) begin
      bad++;
      $display("FAIL %s kind=%0d off=%0d be=%0d: actual err=%0b res=%h expected err=%0b res=%h",
               req, kd, a, be, err, res, exp[32], exp[31:0]);
    end
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0;
    strap = s;
    kind = 3'd0; addr = 2'd0; mem = 32'h0; old = 32'h0;
    repeat (3) @(negedge clk);
    // R1: big-endian while in reset
    check("R1", 1'b1, 3'd1, 2'd0, 32'h11223344, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic t_endian_capture_R1(input logic s);
    do_reset(s);
    check("R1", s, 3'd1, 2'd0, 32'h11223344, 32'h0);
    strap = ~s;
    repeat (3) @(posedge clk);
    check("R1", s, 3'd1, 2'd0, 32'hA1B2C3D4, 32'h0);
    strap = s;
  endtask

  task automatic t_bytes(input logic be);
    for (int a = 0; a < 4; a++) begin
      check("R2", be, 3'd1, 2'(a), 32'h0A1B2C3D, 32'h55555555);
      check("R3", be, 3'd0, 2'(a), 32'hFE80FE7F, 32'h0);
      check("R4", be, 3'd1, 2'(a), 32'hFE80FE7F, 32'hFFFFFFFF);
      check("R11", be, 3'd0, 2'(a), 32'h12345678, 32'h0);
    end
  endtask

  task automatic t_halves(input logic be);
    for (int a = 0; a < 4; a++) begin
      check(a[0] ? "R7" : "R5", be, 3'd2, 2'(a), 32'h8001FF7E, 32'hCAFEF00D);
      check(a[0] ? "R7" : "R5", be, 3'd3, 2'(a), 32'h8001FF7E, 32'hCAFEF00D);
    end
  endtask

  task automatic t_words(input logic be);
    for (int a = 0; a < 4; a++)
      check(a == 0 ? "R6" : "R7", be, 3'd4, 2'(a), 32'hDEADBEEF, 32'h01234567);
  endtask

  task automatic t_left_right(input logic be);
    for (int a = 0; a < 4; a++) begin
      check(be ? "R8" : "R10", be, 3'd5, 2'(a), 32'h11223344, 32'hAABBCCDD);
      check(be ? "R9" : "R10", be, 3'd6, 2'(a), 32'h11223344, 32'hAABBCCDD);
      check("R11", be, 3'd5, 2'(a), 32'hF0E1D2C3, 32'h00000000);
      check("R11", be, 3'd6, 2'(a), 32'hF0E1D2C3, 32'hFFFFFFFF);
    end
  endtask

  task automatic t_unused_R12(input logic be);
    for (int a = 0; a < 4; a++)
      check("R12", be, 3'd7, 2'(a), 32'h99999999, 32'h13579BDF);
  endtask

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; strap = 1'b1;
    kind = 3'd0; addr = 2'd0; mem = 32'h0; old = 32'h0;
    fork
      begin
        t_endian_capture_R1(1'b1);
        t_bytes(1'b1);
        t_halves(1'b1);
        t_words(1'b1);
        t_left_right(1'b1);
        t_unused_R12(1'b1);
        t_endian_capture_R1(1'b0);
        t_bytes(1'b0);
        t_halves(1'b0);
        t_words(1'b0);
        t_left_right(1'b0);
        t_unused_R12(1'b0);
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule